// File: doc/BRIEF.md
# Timestamp Queuing Arbiter

This block shares one resource among several requesters and serves them strictly in the order their requests arrived. A free-running time counter advances once per arrival interval. When a request line goes from low to high, the current count is recorded as that requester's stamp. When the resource is free, the arbiter grants the pending requester whose stamp is oldest.

Age is measured as the distance from the stamp to the current count, modulo the counter range. This lets the counter wrap without disturbing the order. The stamp width is derived from three parameters: the requester count, the longest service time and the arrival interval. The stamp range is twice the requester count times the longest service time, divided by the arrival interval.

A granted requester keeps the resource until it pulses the release input. The holder's stamp is then discarded, and the next grant is issued one cycle later. A requester that keeps its line high after release is not queued again. It must drop the line and raise it once more.

Top module: `tsq_arbiter`

## Requirements
- R1: The grant vector is always one-hot or all zero.
- R2: A request line rising while its requester has no pending stamp records the current time count. Among pending requesters the one with the oldest stamp is granted, so service follows arrival order.
- R3: Requesters stamped in the same clock cycle are served lowest index first.
- R4: A grant stays unchanged until `done_i` is high at a clock edge. At that edge the grant drops to all zero.
- R5: At release, the holder's stamp is discarded. A released requester is never granted again unless it raises a fresh request.
- R6: A stamp is taken only on a low-to-high transition of a request line. A line held high creates no further stamp.
- R7: Ages are computed modulo 2^STAMP_W. A request stamped just before the counter wraps is still served before one stamped just after the wrap.
- R8: `done_i` while nothing is granted has no effect: pending stamps stay, and a request rising in that cycle is still recorded.
- R9: During and right after reset the grant is all zero, no stamp is pending, and the time count is zero.
- R10: With no current holder, a request rising at clock edge k is granted at edge k+1. A new grant also follows one edge after a release whenever a stamp is pending.
- R11: The time count advances by exactly one every ARRIVAL_IVL cycles. STAMP_W is the smallest width whose range covers ceil(2·N_REQ·MAX_SVC / ARRIVAL_IVL).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_REQ | Request lines, one per requester; a rising level queues the requester |
| done_i | input | 1 | Release pulse from the current holder |
| grant_o | output | N_REQ | One-hot grant, all zero when the resource is free |

## Verification
The main function is driven with several arrival patterns:
- Staggered arrivals, one requester per cycle. These separate true arrival order from index priority, because a lower index that arrives later must wait.
- A requester that releases and re-requests while others are queued. This shows that a new stamp goes to the back of the queue.
- Two requesters rising in the same cycle. This isolates the lowest-index tie-break.
- A long hold that lets the counter wrap between two arrivals. Here a plain unsigned stamp comparison would pick the wrong requester, so the modular age comparison is exercised.
- Lines kept high after release, and release pulses sent while idle. These show that neither creates or destroys a queue entry.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

    // Smallest width whose range covers ceil(2 * n * tmax / ta) ticks.
    function automatic int stamp_width(input int n, input int tmax, input int ta);
        int span;
        int w;
        span = (2 * n * tmax + ta - 1) / ta;
        w = 1;
        while ((1 << w) < span) begin
            w++;
        end
        return w;
    endfunction

endpackage

// File: rtl/tsq_ticker.sv
module tsq_ticker #(
    parameter int ARRIVAL_IVL = 1,
    parameter int STAMP_W     = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [STAMP_W-1:0] now_o
);
    localparam int DIV_W = (ARRIVAL_IVL > 1) ? $clog2(ARRIVAL_IVL) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(ARRIVAL_IVL - 1);

    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic [STAMP_W-1:0] now;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.div == DIV_LAST) begin
            st_d.div = '0;
            st_d.now = st_q.now + 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign now_o = st_q.now;

    // R11: the count only ever moves forward by one step
    assert_tick_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (now_o != $past(now_o)) |-> (now_o == STAMP_W'($past(now_o) + 1'b1)));

endmodule

// File: rtl/tsq_stamp_bank.sv
module tsq_stamp_bank #(
    parameter int N_REQ   = 4,
    parameter int STAMP_W = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_REQ-1:0]               req_i,
    input  logic [N_REQ-1:0]               clr_i,
    input  logic [STAMP_W-1:0]             now_i,
    output logic [N_REQ-1:0]               valid_o,
    output logic [N_REQ-1:0][STAMP_W-1:0]  stamp_o
);
    typedef struct packed {
        logic [N_REQ-1:0]              req_prev;
        logic [N_REQ-1:0]              valid;
        logic [N_REQ-1:0][STAMP_W-1:0] stamp;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.req_prev = req_i;
        for (int i = 0; i < N_REQ; i++) begin
            if (clr_i[i]) begin
                st_d.valid[i] = 1'b0;
            end else if (req_i[i] && !st_q.req_prev[i] && !st_q.valid[i]) begin
                st_d.valid[i] = 1'b1;
                st_d.stamp[i] = now_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign stamp_o = st_q.stamp;

    for (genvar g = 0; g < N_REQ; g++) begin : g_chk
        // R6: a pending stamp never changes until its entry is released
        assert_stamp_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.valid[g] && !clr_i[g]) |=> (st_q.valid[g] && $stable(st_q.stamp[g])));
        // R6: a line with no rising transition creates no entry
        assert_no_level_stamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!st_q.valid[g] && !(req_i[g] && !st_q.req_prev[g])) |=> !st_q.valid[g]);
    end

endmodule

// File: rtl/tsq_oldest_pick.sv
module tsq_oldest_pick #(
    parameter int N_REQ   = 4,
    parameter int STAMP_W = 5
) (
    input  logic [N_REQ-1:0]              valid_i,
    input  logic [N_REQ-1:0][STAMP_W-1:0] stamp_i,
    input  logic [STAMP_W-1:0]            now_i,
    output logic [N_REQ-1:0]              pick_o,
    output logic                          any_o
);
    logic [N_REQ-1:0][STAMP_W-1:0] age;
    logic [STAMP_W-1:0]            best_age;
    logic                          found;

    // modular age: the distance the counter has moved since the stamp
    for (genvar g = 0; g < N_REQ; g++) begin : g_age
        assign age[g] = now_i - stamp_i[g];
    end

    // strict greater-than keeps the lowest index on equal ages
    always_comb begin
        pick_o   = '0;
        best_age = '0;
        found    = 1'b0;
        for (int i = 0; i < N_REQ; i++) begin
            if (valid_i[i] && (!found || age[i] > best_age)) begin
                pick_o    = '0;
                pick_o[i] = 1'b1;
                best_age  = age[i];
                found     = 1'b1;
            end
        end
        any_o = found;
    end

endmodule

// File: rtl/tsq_arbiter.sv
module tsq_arbiter #(
    parameter int N_REQ       = 4,
    parameter int ARRIVAL_IVL = 1,
    parameter int MAX_SVC     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic             done_i,
    output logic [N_REQ-1:0] grant_o
);
    localparam int STAMP_W = tsq_pkg::stamp_width(N_REQ, MAX_SVC, ARRIVAL_IVL);

    typedef struct packed {
        logic [N_REQ-1:0] grant;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic [STAMP_W-1:0]            now;
    logic [N_REQ-1:0]              valid;
    logic [N_REQ-1:0][STAMP_W-1:0] stamps;
    logic [N_REQ-1:0]              pick;
    logic                          pick_any;
    logic [N_REQ-1:0]              release_vec;

    assign release_vec = st_q.grant & {N_REQ{done_i}};

    tsq_ticker #(
        .ARRIVAL_IVL (ARRIVAL_IVL),
        .STAMP_W     (STAMP_W)
    ) u_ticker (
        .clk   (clk),
        .rst_n (rst_n),
        .now_o (now)
    );

    tsq_stamp_bank #(
        .N_REQ   (N_REQ),
        .STAMP_W (STAMP_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .clr_i   (release_vec),
        .now_i   (now),
        .valid_o (valid),
        .stamp_o (stamps)
    );

    tsq_oldest_pick #(
        .N_REQ   (N_REQ),
        .STAMP_W (STAMP_W)
    ) u_pick (
        .valid_i (valid),
        .stamp_i (stamps),
        .now_i   (now),
        .pick_o  (pick),
        .any_o   (pick_any)
    );

    always_comb begin
        st_d = st_q;
        if (|st_q.grant) begin
            if (done_i) st_d.grant = '0;
        end else if (pick_any) begin
            st_d.grant = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_o = st_q.grant;

    // R1: never more than one holder
    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));
    // R2: the holder owns a pending stamp
    assert_grant_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |-> (|(grant_o & valid)));
    // R4: no change of holder without a release
    assert_grant_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && !done_i) |=> (grant_o == $past(grant_o)));
    // R4: a release frees the resource at once
    assert_release_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && done_i) |=> (grant_o == '0));
    // R5: the released entry is gone
    assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && done_i) |=> ((valid & $past(grant_o)) == '0));
    // R10: a free resource with a pending stamp is granted on the next edge
    assert_idle_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o == '0) && (|valid)) |=> (|grant_o));

endmodule

// File: tb/tsq_arbiter_test.sv
module tsq_arbiter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 4;
    localparam int NVEC = 24;

    // {req[3:0], done, expected grant[3:0]}
    localparam logic [8:0] VEC [NVEC] = '{
        9'b0001_0_0000, 9'b0001_0_0001, 9'b0011_0_0001, 9'b0111_0_0001,
        9'b1111_0_0001, 9'b1111_1_0000, 9'b1110_0_0010, 9'b1111_0_0010,
        9'b1111_1_0000, 9'b1111_0_0100, 9'b1111_1_0000, 9'b1111_0_1000,
        9'b1111_1_0000, 9'b1111_0_0001, 9'b0000_1_0000, 9'b0000_0_0000,
        9'b1010_0_0000, 9'b1010_0_0010, 9'b1010_1_0000, 9'b1010_0_1000,
        9'b0000_1_0000, 9'b0000_1_0000, 9'b0001_1_0000, 9'b0001_0_0001
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] req = '0;
    logic          done = 1'b0;
    logic [NR-1:0] grant;
    int            checks = 0;
    int            errors = 0;

    tsq_arbiter #(.N_REQ(NR), .ARRIVAL_IVL(1), .MAX_SVC(4)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .done_i  (done),
        .grant_o (grant)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string step_tag(input int s);
        if (s <= 1)       return "R10";
        else if (s == 5 || s == 8 || s == 10 || s == 12) return "R4";
        else if (s <= 13) return "R2";
        else if (s <= 15) return "R5";
        else if (s <= 19) return "R3";
        else              return "R8";
    endfunction

    task automatic check(input logic [NR-1:0] act, input logic [NR-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: grant actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // drive just after an edge, then sample one time unit after the next edge
    task automatic step(input logic [NR-1:0] r, input logic d);
        req  = r;
        done = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req   = '0;
        done  = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(grant, '0, "R9");
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R4: watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();

        for (int s = 0; s < NVEC; s++) begin
            step(VEC[s][8:5], VEC[s][4]);
            check(grant, VEC[s][3:0], step_tag(s));
            checks++;
            if (!$onehot0(grant)) begin
                errors++;
                $display("FAIL R1: grant actual=%b expected=one-hot or zero", grant);
            end
        end

        // R7 / R11: r3 stamped near the top of the count, r1 after it wraps
        do_reset();
        step(4'b0001, 1'b0);
        step(4'b0001, 1'b0);
        check(grant, 4'b0001, "R10");
        for (int k = 2; k < 28; k++) step(4'b0001, 1'b0);
        for (int k = 28; k < 34; k++) step(4'b1001, 1'b0);
        for (int k = 34; k < 36; k++) step(4'b1011, 1'b0);
        check(grant, 4'b0001, "R4");
        step(4'b1011, 1'b1);
        check(grant, 4'b0000, "R4");
        step(4'b1011, 1'b0);
        check(grant, 4'b1000, "R7");
        step(4'b1011, 1'b1);
        step(4'b1011, 1'b0);
        check(grant, 4'b0010, "R11");
        step(4'b1011, 1'b1);
        step(4'b1011, 1'b0);
        // lines still high after release create no new entry
        check(grant, 4'b0000, "R6");
        step(4'b1011, 1'b0);
        check(grant, 4'b0000, "R6");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule